// File: doc/BRIEF.md
# Timed Drawbridge Motor Controller

This block drives one reversible bridge motor through two enable outputs. It keeps the bridge on a fixed schedule: it holds it down for one programmable interval and up for another, and repeats. Two cooperating state machines share the work:

- A target sequencer decides whether the bridge ought to be down or up at each moment.
- A motor machine turns that target, the two limit switches and a lock timer into a drive direction.

Raising stops as soon as the top switch closes. Lowering keeps driving for a programmed number of ticks after the bottom switch closes, so the bridge is pushed firmly into its seat.

Time is counted in strobes on a tick input, not in clock cycles. The motor machine still reacts to the switches and to the target on every clock. The switch inputs must already be synchronised to the clock. After any reset the controller begins from its initial states and brings the bridge to a consistent position, wherever the bridge happened to be.

Top module: `bridge_motor_ctl`

## Requirements
- R1: While reset is low, and on the first clock after it is released, `tgt_up` is 0, `mst` is 0 (idle) and both motor enables are 0.
- R2: `tgt_up` (0 = target down, 1 = target up) stays 0 for DOWN_TICKS tick strobes and then 1 for UP_TICKS tick strobes, repeating. It changes only on a clock edge where `tick` is high.
- R3: `mst` encodes the motor state as 0 idle, 1 raising, 2 lowering, 3 lowering-lock. `mot_up` is high exactly in state 1, and `mot_dn` is high exactly in states 2 and 3.
- R4: From idle, the machine moves to raising when the target is up and `sw_up` is open. It moves to lowering when the target is down and `sw_dn` is open. Otherwise it stays idle.
- R5: In raising with the target up, a closed `sw_up` returns the machine to idle on the next clock. While `sw_up` stays open, it keeps raising.
- R6: In lowering with the target down, a closed `sw_dn` moves the machine to lowering-lock on the next clock.
- R7: Lowering-lock holds the motor down for LOCK_TICKS tick strobes and then returns to idle. Its timer restarts from zero on every entry.
- R8: A target of down while raising moves the machine to lowering on the next clock. A target of up while lowering or in lowering-lock moves it to raising on the next clock.
- R9: `mot_up` and `mot_dn` are never high together.
- R10: After a reset taken with the bridge at any position, the bridge ends at the bottom with the motor idle within the first down phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick | input | 1 | Time-base strobe, one clock wide |
| sw_up | input | 1 | Top limit switch, 1 = closed, synchronised |
| sw_dn | input | 1 | Bottom limit switch, 1 = closed, synchronised |
| mot_up | output | 1 | Drive motor upward |
| mot_dn | output | 1 | Drive motor downward |
| tgt_up | output | 1 | Target position, 1 = up |
| mst | output | 2 | Motor state code |

## Verification
The assertions assume that `tick`, `sw_up` and `sw_dn` are clean, clock-synchronous levels that hold steady around each rising edge. They make no assumption about the switches agreeing with each other or with the target. The stimulus changes every input only on the falling clock edge.

A moving-bridge model drives the switches during scheduled operation and during reset-recovery sweeps over every start position. A final phase drives arbitrary switch pairs, including both switches closed at once, so that every conflict between target and motor state is reached.

// File: rtl/bridge_motor_ctl.sv
module bridge_motor_ctl #(
  parameter int unsigned DOWN_TICKS = 40,
  parameter int unsigned UP_TICKS   = 40,
  parameter int unsigned LOCK_TICKS = 5
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       sw_up,
  input  logic       sw_dn,
  output logic       mot_up,
  output logic       mot_dn,
  output logic       tgt_up,
  output logic [1:0] mst
);
  localparam int unsigned PMAX = (DOWN_TICKS > UP_TICKS) ? DOWN_TICKS : UP_TICKS;
  localparam int unsigned TW   = $clog2(PMAX + 1);
  localparam int unsigned LW   = $clog2(LOCK_TICKS + 1);

  localparam logic [1:0] S_IDLE = 2'd0;
  localparam logic [1:0] S_UP   = 2'd1;
  localparam logic [1:0] S_DN   = 2'd2;
  localparam logic [1:0] S_LOCK = 2'd3;

  logic [TW-1:0] ph_cnt;
  logic [LW-1:0] lk_cnt;
  logic [1:0]    st, st_nx;
  logic          ph_last, lock_done;

  assign ph_last   = tgt_up ? (ph_cnt == TW'(UP_TICKS - 1)) : (ph_cnt == TW'(DOWN_TICKS - 1));
  assign lock_done = tick && (lk_cnt == LW'(LOCK_TICKS - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tgt_up <= 1'b0;
      ph_cnt <= '0;
    end else if (tick) begin
      if (ph_last) begin
        tgt_up <= ~tgt_up;
        ph_cnt <= '0;
      end else begin
        ph_cnt <= ph_cnt + 1'b1;
      end
    end
  end

  always_comb begin
    st_nx = st;
    case (st)
      S_IDLE: begin
        if (tgt_up && !sw_up)       st_nx = S_UP;
        else if (!tgt_up && !sw_dn) st_nx = S_DN;
      end
      S_UP: begin
        if (!tgt_up)    st_nx = S_DN;
        else if (sw_up) st_nx = S_IDLE;
      end
      S_DN: begin
        if (tgt_up)     st_nx = S_UP;
        else if (sw_dn) st_nx = S_LOCK;
      end
      S_LOCK: begin
        if (tgt_up)         st_nx = S_UP;
        else if (lock_done) st_nx = S_IDLE;
      end
      default: st_nx = S_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      lk_cnt <= '0;
    end else begin
      st <= st_nx;
      if (st_nx != st)                lk_cnt <= '0;
      else if (tick && st == S_LOCK)  lk_cnt <= lk_cnt + 1'b1;
    end
  end

  assign mst    = st;
  assign mot_up = (st == S_UP);
  assign mot_dn = st[1];
endmodule

// File: rtl/bridge_motor_chk.sv
module bridge_motor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       sw_up,
  input logic       sw_dn,
  input logic       mot_up,
  input logic       mot_dn,
  input logic       tgt_up,
  input logic [1:0] mst
);
  a_r1_reset_state: assert property (@(posedge clk)
    $rose(rst_n) |-> (mst == 2'd0 && !tgt_up && !mot_up && !mot_dn));

  a_r2_target_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    !tick |=> $stable(tgt_up));

  a_r5_stop_at_top: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_up && mst == 2'd1 && sw_up) |=> (mst == 2'd0));

  a_r6_enter_lock: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_up && mst == 2'd2 && sw_dn) |=> (mst == 2'd3));

  a_r8_leave_raise: assert property (@(posedge clk) disable iff (!rst_n)
    (!tgt_up && mst == 2'd1) |=> (mst == 2'd2));

  a_r8_leave_lower: assert property (@(posedge clk) disable iff (!rst_n)
    (tgt_up && mst[1]) |=> (mst == 2'd1));

  a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
    !(mot_up && mot_dn));
endmodule

bind bridge_motor_ctl bridge_motor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .sw_up(sw_up), .sw_dn(sw_dn),
  .mot_up(mot_up), .mot_dn(mot_dn), .tgt_up(tgt_up), .mst(mst)
);

// File: tb/sim_bridge_motor_ctl.sv
module sim_bridge_motor_ctl;
  localparam int KD = 20, KU = 16, KL = 3, TP = 3, TRAVEL = 8;

  logic clk = 0, rst_n = 0, tick = 0, sw_up = 0, sw_dn = 1;
  logic mot_up, mot_dn, tgt_up;
  logic [1:0] mst;

  int checks = 0, errors = 0, cyc = 0, pos = 0;
  bit ov = 0, done = 0;

  always #2 clk = ~clk;

  bridge_motor_ctl #(.DOWN_TICKS(KD), .UP_TICKS(KU), .LOCK_TICKS(KL)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .sw_up(sw_up), .sw_dn(sw_dn),
    .mot_up(mot_up), .mot_dn(mot_dn), .tgt_up(tgt_up), .mst(mst));

  // requirement-level reference model
  logic m_tgt; int m_ph, m_lk, m_st, nst; string m_tag, tg;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_tgt <= 0; m_ph <= 0; m_st <= 0; m_lk <= 0; m_tag <= "R1";
    end else begin
      if (tick) begin
        if (m_ph + 1 == (m_tgt ? KU : KD)) begin m_tgt <= !m_tgt; m_ph <= 0; end
        else m_ph <= m_ph + 1;
      end
      nst = m_st; tg = "R4";
      case (m_st)
        0: begin tg = "R4"; if (m_tgt && !sw_up) nst = 1; else if (!m_tgt && !sw_dn) nst = 2; end
        1: begin tg = "R5"; if (!m_tgt) begin nst = 2; tg = "R8"; end else if (sw_up) nst = 0; end
        2: begin tg = "R6"; if (m_tgt) begin nst = 1; tg = "R8"; end else if (sw_dn) nst = 3; end
        default: begin tg = "R7";
          if (m_tgt) begin nst = 1; tg = "R8"; end
          else if (tick && m_lk + 1 == KL) nst = 0;
        end
      endcase
      m_lk  <= (nst != m_st) ? 0 : ((tick && m_st == 3) ? m_lk + 1 : m_lk);
      m_st  <= nst;
      m_tag <= tg;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at cycle %0d", req, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit tprev;
    @(negedge clk);
    cyc++;
    if (rst_n) begin
      chk(tgt_up == m_tgt, "R2", tgt_up, m_tgt);
      chk(mst == 2'(m_st), m_tag, mst, m_st);
      chk(mot_up == (m_st == 1) && mot_dn == (m_st >= 2), "R3", {mot_up, mot_dn}, m_st);
      chk(!(mot_up && mot_dn), "R9", {mot_up, mot_dn}, 0);
    end
    tprev = tick;
    if (tprev) begin
      if (mot_up && pos < TRAVEL) pos++;
      if (mot_dn && pos > 0) pos--;
    end
    tick = (cyc % TP == 0);
    if (ov) begin
      sw_up = 1'($urandom_range(0, 1));
      sw_dn = 1'($urandom_range(0, 1));
    end else begin
      sw_up = (pos == TRAVEL);
      sw_dn = (pos == 0);
    end
  endtask

  initial begin
    repeat (4) begin
      @(negedge clk);
      chk(mst == 0 && !tgt_up && !mot_up && !mot_dn, "R1", mst, 0);
    end
    rst_n = 1;
    @(posedge clk); #1;
    chk(mst == 0 && !tgt_up, "R1", mst, 0);
    // scheduled operation with a moving bridge
    repeat ((KD + KU) * TP * 3) step();
    // reset recovery from every bridge position
    for (int p = 0; p <= TRAVEL; p++) begin
      repeat (p * 7 + 5) step();
      pos = p;
      @(negedge clk); rst_n = 0;
      sw_up = (pos == TRAVEL); sw_dn = (pos == 0);
      @(negedge clk); rst_n = 1;
      repeat ((TRAVEL + KL + 4) * TP) step();
      chk(pos == 0 && sw_dn && mst == 0 && !mot_dn, "R10", pos * 4 + mst, 0);
    end
    // arbitrary switch patterns against the schedule
    ov = 1;
    repeat (6000) step();
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule